// File: doc/BRIEF.md
# Reloadable DMA Transfer Counter with Chip Identification

This block holds the byte count for a DMA transfer in a storage-bus host adapter. Software programs the count one byte at a time through a small byte-wide register port. Those writes land in shadow registers and do not touch the count the hardware uses. A command byte written with its DMA flag set copies the shadow bytes into the live count. A transfer command turns the live count into a transfer length. A count of zero means the maximum length of 0x10000 bytes. The length is then clipped to the number of bytes the current bus phase still expects.

The data mover sits outside this block. It reports moved bytes through a decrement input and reports the end of a transfer through a done strobe. Terminal count is signalled to the status logic. Reads of the three count bytes return the live count. The high byte is the exception: until software has written it once, reading it returns a fixed identification value. A host can use that value to tell which chip variant is fitted.

Top module: `xfer_count_id`

## Requirements
- R1: Register addresses 0, 1 and 2 hold bits 7:0, 15:8 and 23:16 of the 24-bit live count, so the count equals byte0 + (byte1 << 8) + (byte2 << 16). A read returns the addressed byte on `rd_data_o` one cycle after `reg_rd_i`, and the value holds until the next read.
- R2: A write to any of addresses 0, 1 or 2 clears terminal count on the next edge. A set event in the same cycle (done, or a decrement that reaches zero) takes precedence.
- R3: A byte write updates only a shadow register. The live count, and therefore what reads return, stays the same until a reload.
- R4: A write to address 3 is a command byte. Bit 7 is the DMA flag and bits 6:0 are the opcode. A command with bit 7 set copies the shadow bytes into the live count and sets `dma_mode_o`. A command with bit 7 clear clears `dma_mode_o` and leaves the live count unchanged.
- R5: Opcode 0x10 is the transfer command. One cycle after it is written, `xfer_valid_o` pulses for one cycle, and `xfer_len_o` = min(L, `phase_rem_i`). L is the live count (after any reload by the same command), or 0x10000 when that count is zero.
- R6: `dma_done_i` zeroes the live count and sets terminal count on the next edge.
- R7: A read of address 2 returns the parameter `CHIP_ID` until address 2 has been written once after reset. After that it returns live count bits 23:16.
- R8: `dec_valid_i` lowers the live count by `dec_amt_i`, flooring at zero. Terminal count sets on the same edge at which the count becomes zero.
- R9: Opcode 0x02 is a soft reset. It clears the shadow bytes, the live count, terminal count, DMA mode and the written-once flag, whatever the state of bit 7.
- R10: After the synchronous reset `rst`, the live count is 0, `tc_o`=0, `dma_mode_o`=0, `xfer_valid_o`=0 and `rd_data_o`=0.
- R11: A read of address 3 returns {tc, dma_mode, 6'b0}.
- R12: In a cycle where a reloading command coincides with `dma_done_i` or `dec_valid_i`, the reload sets the live count and terminal count keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address (0..2 count bytes, 3 command/status) |
| reg_wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| phase_rem_i | input | 24 | Bytes the current bus phase still expects |
| dec_valid_i | input | 1 | Data mover moved bytes this cycle |
| dec_amt_i | input | 16 | Number of bytes moved |
| dma_done_i | input | 1 | Transfer completion strobe |
| dma_mode_o | output | 1 | Last command carried the DMA flag |
| tc_o | output | 1 | Terminal count |
| xfer_valid_o | output | 1 | Transfer length valid pulse |
| xfer_len_o | output | 24 | Computed transfer length |

## Verification
The bench reads address 2 before the first high-byte write, after it but before any reload, and again after a soft reset and after a hard reset. A design that treats the high byte as "written once" at the wrong moment returns the ID at the wrong time, or returns the shadow byte instead of the live one. It runs transfer commands with a zero count and with phase limits both above and below the count. A wrong length shows up as 0 instead of 0x10000, or as an unclipped value. It also drives a decrement larger than the remaining count, which a non-saturating design wraps to a large count with no terminal count. Last, it makes a reload collide with done and with a decrement, where a wrong priority zeroes the fresh count or flips terminal count.

// File: rtl/xfer_cnt_pkg.sv
package xfer_cnt_pkg;

  localparam logic [6:0] OP_NOP      = 7'h00;
  localparam logic [6:0] OP_SOFT_RST = 7'h02;
  localparam logic [6:0] OP_XFER     = 7'h10;

  typedef struct packed {
    logic       dma;
    logic [6:0] op;
  } cmd_t;

endpackage

// File: rtl/xcnt_shadow.sv
module xcnt_shadow #(
  parameter int unsigned NBYTES = 3,
  localparam int unsigned CNT_W = 8 * NBYTES,
  localparam int unsigned IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srst_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_byte_i,
  output logic [CNT_W-1:0] shadow_o,
  output logic             hi_written_o
);

  localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(NBYTES - 1);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst || srst_i) begin
        byte_q <= '0;
      end else if (wr_i && (wr_idx_i == IDX_W'(g))) begin
        byte_q <= wr_byte_i;
      end
    end
    assign shadow_o[8*g +: 8] = byte_q;
  end

  always_ff @(posedge clk) begin
    if (rst || srst_i) begin
      hi_written_o <= 1'b0;
    end else if (wr_i && (wr_idx_i == HI_IDX)) begin
      hi_written_o <= 1'b1;
    end
  end

endmodule

// File: rtl/xcnt_live.sv
module xcnt_live #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned DEC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srst_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             done_i,
  input  logic             dec_valid_i,
  input  logic [DEC_W-1:0] dec_amt_i,
  input  logic             tc_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tc_o
);

  logic [CNT_W-1:0] amt_ext;
  logic             dec_floor;
  logic             tc_set;

  assign amt_ext   = CNT_W'(dec_amt_i);
  assign dec_floor = (amt_ext >= count_o);
  assign tc_set    = !load_i && (done_i || (dec_valid_i && dec_floor));

  always_ff @(posedge clk) begin
    if (rst || srst_i) begin
      count_o <= '0;
    end else if (load_i) begin
      count_o <= load_val_i;
    end else if (done_i) begin
      count_o <= '0;
    end else if (dec_valid_i) begin
      count_o <= dec_floor ? '0 : (count_o - amt_ext);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || srst_i) begin
      tc_o <= 1'b0;
    end else if (tc_set) begin
      tc_o <= 1'b1;
    end else if (tc_clr_i) begin
      tc_o <= 1'b0;
    end
  end

endmodule

// File: rtl/xcnt_len.sv
module xcnt_len #(
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned ZERO_SHIFT = 16
) (
  input  logic [CNT_W-1:0] base_i,
  input  logic [CNT_W-1:0] phase_i,
  output logic [CNT_W-1:0] len_o
);

  localparam logic [CNT_W-1:0] ZERO_LEN = CNT_W'(1) << ZERO_SHIFT;

  logic [CNT_W-1:0] raw_len;

  always_comb begin
    raw_len = (base_i == '0) ? ZERO_LEN : base_i;
    len_o   = (raw_len < phase_i) ? raw_len : phase_i;
  end

endmodule

// File: rtl/xfer_count_id.sv
module xfer_count_id
  import xfer_cnt_pkg::*;
#(
  parameter int unsigned NBYTES     = 3,
  parameter int unsigned DEC_W      = 16,
  parameter int unsigned ZERO_SHIFT = 16,
  parameter logic [7:0]  CHIP_ID    = 8'hA2,
  localparam int unsigned CNT_W     = 8 * NBYTES,
  localparam int unsigned ADDR_W    = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        rd_data_o,
  input  logic [CNT_W-1:0]  phase_rem_i,
  input  logic              dec_valid_i,
  input  logic [DEC_W-1:0]  dec_amt_i,
  input  logic              dma_done_i,
  output logic              dma_mode_o,
  output logic              tc_o,
  output logic              xfer_valid_o,
  output logic [CNT_W-1:0]  xfer_len_o
);

  localparam int unsigned       IDX_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(NBYTES);
  localparam logic [IDX_W-1:0]  HI_IDX   = IDX_W'(NBYTES - 1);

  cmd_t             cmd;
  logic             cnt_wr;
  logic             cmd_wr;
  logic             soft_rst;
  logic             load;
  logic             xfer_go;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] shadow;
  logic [CNT_W-1:0] live_cnt;
  logic             hi_written;
  logic [CNT_W-1:0] len_base;
  logic [CNT_W-1:0] len_calc;
  logic [7:0]       rd_next;

  assign cmd      = cmd_t'(reg_wdata_i);
  assign idx      = IDX_W'(reg_addr_i);
  assign cnt_wr   = reg_wr_i && (reg_addr_i < CMD_ADDR);
  assign cmd_wr   = reg_wr_i && (reg_addr_i == CMD_ADDR);
  assign soft_rst = cmd_wr && (cmd.op == OP_SOFT_RST);
  assign load     = cmd_wr && cmd.dma && !soft_rst;
  assign xfer_go  = cmd_wr && (cmd.op == OP_XFER);
  assign len_base = load ? shadow : live_cnt;

  xcnt_shadow #(.NBYTES(NBYTES)) u_shadow (
    .clk          (clk),
    .rst          (rst),
    .srst_i       (soft_rst),
    .wr_i         (cnt_wr),
    .wr_idx_i     (idx),
    .wr_byte_i    (reg_wdata_i),
    .shadow_o     (shadow),
    .hi_written_o (hi_written)
  );

  xcnt_live #(.CNT_W(CNT_W), .DEC_W(DEC_W)) u_live (
    .clk         (clk),
    .rst         (rst),
    .srst_i      (soft_rst),
    .load_i      (load),
    .load_val_i  (shadow),
    .done_i      (dma_done_i),
    .dec_valid_i (dec_valid_i),
    .dec_amt_i   (dec_amt_i),
    .tc_clr_i    (cnt_wr),
    .count_o     (live_cnt),
    .tc_o        (tc_o)
  );

  xcnt_len #(.CNT_W(CNT_W), .ZERO_SHIFT(ZERO_SHIFT)) u_len (
    .base_i  (len_base),
    .phase_i (phase_rem_i),
    .len_o   (len_calc)
  );

  always_comb begin
    if (reg_addr_i == CMD_ADDR) begin
      rd_next = {tc_o, dma_mode_o, 6'b0};
    end else if ((idx == HI_IDX) && !hi_written) begin
      rd_next = CHIP_ID;
    end else begin
      rd_next = live_cnt[8*int'(idx) +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_mode_o   <= 1'b0;
      xfer_valid_o <= 1'b0;
      xfer_len_o   <= '0;
      rd_data_o    <= '0;
    end else begin
      xfer_valid_o <= 1'b0;
      if (rd_data_o != rd_next && reg_rd_i) begin
        rd_data_o <= rd_next;
      end
      if (soft_rst) begin
        dma_mode_o <= 1'b0;
      end else if (cmd_wr) begin
        dma_mode_o <= cmd.dma;
        if (xfer_go) begin
          xfer_valid_o <= 1'b1;
          xfer_len_o   <= len_calc;
        end
      end
    end
  end

endmodule

// File: rtl/xfer_count_id_chk.sv
module xfer_count_id_chk #(
  parameter int unsigned NBYTES  = 3,
  parameter int unsigned DEC_W   = 16,
  parameter logic [7:0]  CHIP_ID = 8'hA2,
  localparam int unsigned CNT_W  = 8 * NBYTES,
  localparam int unsigned ADDR_W = $clog2(NBYTES + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [7:0]        reg_wdata_i,
  input logic [7:0]        rd_data_o,
  input logic [CNT_W-1:0]  phase_rem_i,
  input logic              dec_valid_i,
  input logic [DEC_W-1:0]  dec_amt_i,
  input logic              dma_done_i,
  input logic              dma_mode_o,
  input logic              tc_o,
  input logic              xfer_valid_o,
  input logic [CNT_W-1:0]  xfer_len_o,
  input logic [CNT_W-1:0]  live_cnt,
  input logic              hi_written
);

  logic wr_cnt;
  logic wr_cmd;
  assign wr_cnt = reg_wr_i && (reg_addr_i < ADDR_W'(NBYTES));
  assign wr_cmd = reg_wr_i && (reg_addr_i == ADDR_W'(NBYTES));

  p_byte_wr_clears_tc_r2: assert property (@(posedge clk) disable iff (rst)
    wr_cnt && !dma_done_i && !dec_valid_i |=> !tc_o);

  p_live_held_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_cmd && !dma_done_i && !dec_valid_i |=> $stable(live_cnt));

  p_plain_cmd_clears_dma_r4: assert property (@(posedge clk) disable iff (rst)
    wr_cmd && !reg_wdata_i[7] |=> !dma_mode_o);

  p_flag_cmd_sets_dma_r4: assert property (@(posedge clk) disable iff (rst)
    wr_cmd && reg_wdata_i[7] && (reg_wdata_i[6:0] != 7'h02) |=> dma_mode_o);

  p_len_clipped_r5: assert property (@(posedge clk) disable iff (rst)
    xfer_valid_o |-> xfer_len_o <= $past(phase_rem_i));

  p_len_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    xfer_valid_o && ($past(phase_rem_i) != '0) |-> xfer_len_o != '0);

  p_done_zeroes_r6: assert property (@(posedge clk) disable iff (rst)
    dma_done_i && !wr_cmd |=> tc_o && (live_cnt == '0));

  p_id_before_write_r7: assert property (@(posedge clk) disable iff (rst)
    reg_rd_i && (reg_addr_i == ADDR_W'(NBYTES - 1)) && !hi_written |=> rd_data_o == CHIP_ID);

  p_dec_floor_r8: assert property (@(posedge clk) disable iff (rst)
    dec_valid_i && !dma_done_i && !wr_cmd && (CNT_W'(dec_amt_i) >= live_cnt)
    |=> (live_cnt == '0) && tc_o);

  p_tc_held_on_reload_r12: assert property (@(posedge clk) disable iff (rst)
    wr_cmd && reg_wdata_i[7] && (reg_wdata_i[6:0] != 7'h02) |=> $stable(tc_o));

endmodule

bind xfer_count_id xfer_count_id_chk #(
  .NBYTES  (NBYTES),
  .DEC_W   (DEC_W),
  .CHIP_ID (CHIP_ID)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_wr_i     (reg_wr_i),
  .reg_rd_i     (reg_rd_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .rd_data_o    (rd_data_o),
  .phase_rem_i  (phase_rem_i),
  .dec_valid_i  (dec_valid_i),
  .dec_amt_i    (dec_amt_i),
  .dma_done_i   (dma_done_i),
  .dma_mode_o   (dma_mode_o),
  .tc_o         (tc_o),
  .xfer_valid_o (xfer_valid_o),
  .xfer_len_o   (xfer_len_o),
  .live_cnt     (live_cnt),
  .hi_written   (hi_written)
);

// File: tb/xfer_count_id_bench.sv
module xfer_count_id_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ID = 8'hA2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  rd_data_o;
  logic [23:0] phase_rem_i = 24'hFFFFFF;
  logic        dec_valid_i = 1'b0;
  logic [15:0] dec_amt_i = '0;
  logic        dma_done_i = 1'b0;
  logic        dma_mode_o;
  logic        tc_o;
  logic        xfer_valid_o;
  logic [23:0] xfer_len_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_count_id #(.CHIP_ID(ID)) u_xfer_count_id (
    .clk          (clk),
    .rst          (rst),
    .reg_wr_i     (reg_wr_i),
    .reg_rd_i     (reg_rd_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .rd_data_o    (rd_data_o),
    .phase_rem_i  (phase_rem_i),
    .dec_valid_i  (dec_valid_i),
    .dec_amt_i    (dec_amt_i),
    .dma_done_i   (dma_done_i),
    .dma_mode_o   (dma_mode_o),
    .tc_o         (tc_o),
    .xfer_valid_o (xfer_valid_o),
    .xfer_len_o   (xfer_len_o)
  );

  int    total = 0;
  int    bad = 0;
  bit    finished = 0;
  string tag = "R10";

  // behavioural reference state
  logic [23:0] m_shadow = '0;
  logic [23:0] m_live = '0;
  bit          m_tc = 0, m_dma = 0, m_hiw = 0, m_xv = 0;
  logic [23:0] m_xl = '0;
  logic [7:0]  m_rd = '0;

  task automatic check(string what, logic [23:0] act, logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model();
    bit load, srst;
    logic [23:0] base;
    if (rst) begin
      m_shadow = '0; m_live = '0; m_tc = 0; m_dma = 0; m_hiw = 0;
      m_xv = 0; m_xl = '0; m_rd = '0;
      return;
    end
    m_xv = 0; load = 0; srst = 0;
    if (reg_rd_i) begin
      case (reg_addr_i)
        2'd0: m_rd = m_live[7:0];
        2'd1: m_rd = m_live[15:8];
        2'd2: m_rd = m_hiw ? m_live[23:16] : ID;
        default: m_rd = {m_tc, m_dma, 6'b0};
      endcase
    end
    if (reg_wr_i && reg_addr_i != 2'd3) begin
      m_shadow[8*reg_addr_i +: 8] = reg_wdata_i;
      m_tc = 0;
      if (reg_addr_i == 2'd2) m_hiw = 1;
    end
    if (reg_wr_i && reg_addr_i == 2'd3) begin
      if (reg_wdata_i[6:0] == 7'h02) begin
        srst = 1;
        m_shadow = '0; m_live = '0; m_tc = 0; m_dma = 0; m_hiw = 0;
      end else begin
        m_dma = reg_wdata_i[7];
        if (reg_wdata_i[7]) begin
          m_live = m_shadow;
          load = 1;
        end
        if (reg_wdata_i[6:0] == 7'h10) begin
          base = (m_live == 0) ? 24'h010000 : m_live;
          m_xl = (base < phase_rem_i) ? base : phase_rem_i;
          m_xv = 1;
        end
      end
    end
    if (!load && !srst) begin
      if (dma_done_i) begin
        m_live = '0; m_tc = 1;
      end else if (dec_valid_i) begin
        m_live = ({8'h0, dec_amt_i} >= m_live) ? 24'h0 : m_live - {8'h0, dec_amt_i};
        if (m_live == 0) m_tc = 1;
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model();
    #1;
    check("tc_o", {23'h0, tc_o}, {23'h0, m_tc});
    check("dma_mode_o", {23'h0, dma_mode_o}, {23'h0, m_dma});
    check("xfer_valid_o", {23'h0, xfer_valid_o}, {23'h0, m_xv});
    if (m_xv) check("xfer_len_o", xfer_len_o, m_xl);
    check("rd_data_o", {16'h0, rd_data_o}, {16'h0, m_rd});
    reg_wr_i = 0; reg_rd_i = 0; dec_valid_i = 0; dma_done_i = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    step();
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp);
    reg_rd_i = 1; reg_addr_i = a;
    step();
    check("read value", {16'h0, rd_data_o}, {16'h0, exp});
  endtask

  task automatic load24(logic [23:0] v);
    wr(2'd0, v[7:0]); wr(2'd1, v[15:8]); wr(2'd2, v[23:16]); wr(2'd3, 8'h80);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    tag = "R10";
    repeat (3) step();
    rst = 0;
    step();
    rd(2'd0, 8'h00);
    rd(2'd3, 8'h00);
    // R7: ID before any high-byte write
    tag = "R7";
    rd(2'd2, ID);
    // R3: byte writes stay in shadow
    tag = "R3";
    wr(2'd0, 8'h34); wr(2'd1, 8'h12);
    rd(2'd0, 8'h00);
    rd(2'd1, 8'h00);
    tag = "R7";
    rd(2'd2, ID);
    wr(2'd2, 8'h05);
    rd(2'd2, 8'h00);           // live high byte, not shadow, not ID
    // R1 / R4: reload on flagged command
    tag = "R1";
    wr(2'd3, 8'h80);
    rd(2'd0, 8'h34); rd(2'd1, 8'h12); rd(2'd2, 8'h05);
    tag = "R11";
    rd(2'd3, 8'h40);
    tag = "R4";
    wr(2'd0, 8'hEE);
    wr(2'd3, 8'h00);
    rd(2'd0, 8'h34);           // plain command does not reload
    rd(2'd3, 8'h00);
    // R5: transfer length
    tag = "R5";
    phase_rem_i = 24'h000100;
    wr(2'd0, 8'h34);
    wr(2'd3, 8'h90);
    check("R5 clip to phase", xfer_len_o, 24'h000100);
    phase_rem_i = 24'hFFFFFF;
    wr(2'd3, 8'h10);
    check("R5 full count", xfer_len_o, 24'h051234);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    wr(2'd3, 8'h90);
    check("R5 zero means max", xfer_len_o, 24'h010000);
    phase_rem_i = 24'h00FFFF;
    wr(2'd3, 8'h10);
    check("R5 zero clipped", xfer_len_o, 24'h00FFFF);
    phase_rem_i = 24'hFFFFFF;
    // R8: decrement with floor
    tag = "R8";
    load24(24'h000010);
    dec_valid_i = 1; dec_amt_i = 16'd6; step();
    rd(2'd0, 8'h0A);
    dec_valid_i = 1; dec_amt_i = 16'h0020; step();
    rd(2'd0, 8'h00);
    rd(2'd3, 8'hC0);
    // R2: byte write clears tc
    tag = "R2";
    wr(2'd1, 8'h02);
    rd(2'd3, 8'h40);
    // R6: done
    tag = "R6";
    load24(24'h030201);
    dma_done_i = 1; step();
    rd(2'd0, 8'h00); rd(2'd2, 8'h00);
    rd(2'd3, 8'hC0);
    // R12: reload beats done and decrement
    tag = "R12";
    wr(2'd0, 8'h44);
    reg_wr_i = 1; reg_addr_i = 2'd3; reg_wdata_i = 8'h80; dma_done_i = 1; step();
    rd(2'd0, 8'h44);
    reg_wr_i = 1; reg_addr_i = 2'd3; reg_wdata_i = 8'h80; dec_valid_i = 1;
    dec_amt_i = 16'hFFFF; step();
    rd(2'd0, 8'h44);
    // R9: soft reset
    tag = "R9";
    wr(2'd3, 8'h82);
    rd(2'd2, ID);
    wr(2'd3, 8'h80);
    rd(2'd0, 8'h00); rd(2'd1, 8'h00);
    wr(2'd3, 8'h00);
    rd(2'd3, 8'h00);
    // R10 / R7: hard reset re-arms ID
    tag = "R10";
    wr(2'd2, 8'h09);
    rst = 1; step(); rst = 0; step();
    rd(2'd2, ID);
    // mixed traffic against the reference model
    tag = "R3";
    for (int i = 0; i < 400; i++) begin
      int k;
      k = $urandom_range(0, 9);
      phase_rem_i = (k < 5) ? 24'($urandom_range(0, 24'h020000)) : 24'hFFFFFF;
      if (k < 3) begin
        reg_wr_i = 1; reg_addr_i = 2'($urandom_range(0, 2));
        reg_wdata_i = 8'($urandom_range(0, 255));
      end else if (k < 5) begin
        reg_wr_i = 1; reg_addr_i = 2'd3;
        case ($urandom_range(0, 5))
          0: reg_wdata_i = 8'h02;
          1, 2: reg_wdata_i = 8'h10;
          default: reg_wdata_i = 8'h00;
        endcase
        reg_wdata_i[7] = 1'($urandom_range(0, 1));
      end else begin
        reg_rd_i = 1; reg_addr_i = 2'($urandom_range(0, 3));
      end
      if (k == 6) dma_done_i = ($urandom_range(0, 3) == 0);
      if (k >= 7) begin
        dec_valid_i = 1; dec_amt_i = 16'($urandom_range(0, 600));
      end
      step();
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule